// File: doc/BRIEF.md
# PCI host bridge register interface

This block is the CPU-facing control window of a small PCI host controller. It sits on a 32-bit register bus and holds four kinds of state. The first is the bridge's own 256-byte configuration space. The second is a register holding the target address for configuration cycles. The last two are registers that place the memory window and the IO window. Software does not reach downstream configuration space directly. It loads the target address into the configuration address register, then reads or writes a data port. Each data-port access becomes one 4-byte request on a simple request/done interface, and the CPU bus is stalled until that request finishes.

The block drives the current IO window base (address bits 31:18, which gives a window of 0x40000 bytes) as an output. It pulses a relocation event when that base really moves. Writes that leave the upper base bits unchanged do nothing at all. The block also routes four per-slot interrupt lines: a device in slot N, where N is devfn shifted right by three, drives output N.

Top module: `pcib_regif`

## Requirements
- R1: After reset the IO base register reads 0xFE240000 and io_base is 0x3F89. The address and memory base registers read 0. The configuration word at offset 0x004 reads 0x02900080: command bit 7 (wait control), and status bits 4 (capability list), 7 (fast back-to-back) and 9 (medium select timing). Every other configuration word reads 0.
- R2: Word-aligned offsets 0x000 to 0x0FC are read/write storage of 64 32-bit words. A read returns the last word written to that offset.
- R3: Offset 0x1C0 (configuration address) stores the written word unmodified and reads it back.
- R4: Offset 0x1C4 (memory base) stores the written data ANDed with 0xFF000001, and reads return that masked value.
- R5: A write to offset 0x1C8 (IO base) whose bits 31:18 differ from the stored bits 31:18 stores the data ANDed with 0xFFFC0001. A write whose bits 31:18 match changes nothing, not even bit 0.
- R6: io_reloc is high for exactly the one cycle after a write that moves the IO base, and io_base already shows the new bits 31:18 in that cycle. There is no pulse in any other case.
- R7: A write to offset 0x220 raises cfg_req with cfg_wr=1, cfg_addr equal to the configuration address register, and cfg_wdata equal to the bus data. These stay stable until cfg_done. bus_ready stays low from the first cycle of the access until the cycle after cfg_done.
- R8: A read of offset 0x220 raises cfg_req with cfg_wr=0 at the configuration address. The read returns the cfg_rdata value captured in the cycle cfg_done was high.
- R9: Reads of unmapped offsets return 0 and writes to them change no state. Unmapped offsets are those with bits 1:0 not zero, 0x100 to 0x1BC, 0x1CC to 0x21C, and 0x224 and above.
- R10: irq_out[n] follows slot_irq_in[n] for each of the four slots, with no delay.
- R11: Every access other than the data port completes in the cycle it is presented, with bus_ready high. A write takes effect at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready |
| bus_ready | output | 1 | Access completes at this edge |
| cfg_req | output | 1 | Downstream configuration request |
| cfg_wr | output | 1 | Request is a write |
| cfg_addr | output | 32 | Configuration target address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data |
| cfg_done | input | 1 | Request finished |
| io_base | output | 14 | IO window base, address bits 31:18 |
| io_reloc | output | 1 | One-cycle IO window relocation pulse |
| slot_irq_in | input | 4 | Per-slot interrupt inputs |
| irq_out | output | 4 | Routed interrupt outputs |

## Verification
The IO base write with unchanged upper bits but a different bit 0 is the sharpest corner. A design that compares whole words would store the new bit 0 and pulse io_reloc. A design that forgets to compare would relocate on every write. Data-port accesses are run with downstream latencies from zero to three cycles. This catches a port that reads cfg_rdata too early, drops ready before done, or sends the old address after the address register changes. Mask errors on the base registers, reset values in the command/status word, and decode holes are exercised by random writes to the window edges, misaligned offsets and the unmapped gaps, each followed by read-backs.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  localparam int ADDR_W = 10;
  localparam int IOWIN_LSB = 18;
  localparam int IOBASE_W = 32 - IOWIN_LSB;

  localparam logic [ADDR_W-1:0] OFS_CADDR  = 10'h1C0;
  localparam logic [ADDR_W-1:0] OFS_MBASE  = 10'h1C4;
  localparam logic [ADDR_W-1:0] OFS_IOBASE = 10'h1C8;
  localparam logic [ADDR_W-1:0] OFS_DPORT  = 10'h220;

  localparam logic [31:0] MBASE_KEEP  = 32'hFF00_0001;
  localparam logic [31:0] IOBASE_KEEP = 32'hFFFC_0001;
  localparam logic [31:0] IOBASE_RST  = 32'hFE24_0000;
  // status = cap list | fast b2b | medium select timing, command = wait control
  localparam logic [31:0] CMDSTAT_RST = 32'h0290_0080;
  localparam int CMDSTAT_IDX = 1;

  typedef enum logic [2:0] {
    HIT_NONE, HIT_CFG, HIT_CADDR, HIT_MBASE, HIT_IOBASE, HIT_DPORT
  } hit_e;

  function automatic hit_e decode(input logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00)        return HIT_NONE;
    if (a[ADDR_W-1:8] == '0)    return HIT_CFG;
    case (a)
      OFS_CADDR:  return HIT_CADDR;
      OFS_MBASE:  return HIT_MBASE;
      OFS_IOBASE: return HIT_IOBASE;
      OFS_DPORT:  return HIT_DPORT;
      default:    return HIT_NONE;
    endcase
  endfunction

  function automatic logic [31:0] mbase_mask(input logic [31:0] v);
    return v & MBASE_KEEP;
  endfunction

  function automatic logic [31:0] iobase_mask(input logic [31:0] v);
    return v & IOBASE_KEEP;
  endfunction

  function automatic logic iobase_moves(input logic [31:0] old_v, input logic [31:0] new_v);
    return old_v[31:IOWIN_LSB] != new_v[31:IOWIN_LSB];
  endfunction

  function automatic logic [31:0] cfg_word_rst(input int idx);
    return (idx == CMDSTAT_IDX) ? CMDSTAT_RST : 32'h0;
  endfunction
endpackage

// File: rtl/pcib_cfgspace.sv
module pcib_cfgspace #(
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  logic [31:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         word_q[g] <= pcib_pkg::cfg_word_rst(g);
      else if (we && idx == IDX_W'(g))    word_q[g] <= wdata;
    end
  end

  assign rdata = word_q[idx];
endmodule

// File: rtl/pcib_winregs.sv
module pcib_winregs
  import pcib_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_caddr,
  input  logic                we_mbase,
  input  logic                we_iobase,
  input  logic [31:0]         wdata,
  output logic [31:0]         caddr,
  output logic [31:0]         mbase,
  output logic [31:0]         iobase,
  output logic [IOBASE_W-1:0] io_base,
  output logic                io_reloc
);
  logic move_evt;
  assign move_evt = we_iobase && iobase_moves(iobase, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caddr    <= '0;
      mbase    <= '0;
      iobase   <= IOBASE_RST;
      io_reloc <= 1'b0;
    end else begin
      if (we_caddr) caddr  <= wdata;
      if (we_mbase) mbase  <= mbase_mask(wdata);
      if (move_evt) iobase <= iobase_mask(wdata);
      io_reloc <= move_evt;
    end
  end

  assign io_base = iobase[31:IOWIN_LSB];
endmodule

// File: rtl/pcib_cfgport.sv
module pcib_cfgport (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic        acc_wr,
  input  logic [31:0] acc_addr,
  input  logic [31:0] acc_wdata,
  output logic        port_ready,
  output logic [31:0] port_rdata,
  output logic        cfg_req,
  output logic        cfg_wr,
  output logic [31:0] cfg_addr,
  output logic [31:0] cfg_wdata,
  input  logic [31:0] cfg_rdata,
  input  logic        cfg_done
);
  typedef enum logic [1:0] {P_IDLE, P_WAIT, P_DONE} pst_e;
  pst_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= P_IDLE;
      cfg_wr     <= 1'b0;
      cfg_addr   <= '0;
      cfg_wdata  <= '0;
      port_rdata <= '0;
    end else begin
      case (st_q)
        P_IDLE: if (acc) begin
          st_q      <= P_WAIT;
          cfg_wr    <= acc_wr;
          cfg_addr  <= acc_addr;
          cfg_wdata <= acc_wdata;
        end
        P_WAIT: if (cfg_done) begin
          st_q       <= P_DONE;
          port_rdata <= cfg_rdata;
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign cfg_req    = (st_q == P_WAIT);
  assign port_ready = (st_q == P_DONE);
endmodule

// File: rtl/pcib_irqroute.sv
module pcib_irqroute #(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0] slot_irq_in,
  output logic [SLOTS-1:0] irq_out
);
  // a device at devfn d signals on output d >> 3, i.e. its slot number
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int DEVFN = s << 3;
    assign irq_out[DEVFN >> 3] = slot_irq_in[s];
  end
endmodule

// File: rtl/pcib_regif.sv
module pcib_regif
  import pcib_pkg::*;
#(
  parameter int CFG_WORDS = 64,
  parameter int SLOTS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_ready,
  output logic                cfg_req,
  output logic                cfg_wr,
  output logic [31:0]         cfg_addr,
  output logic [31:0]         cfg_wdata,
  input  logic [31:0]         cfg_rdata,
  input  logic                cfg_done,
  output logic [IOBASE_W-1:0] io_base,
  output logic                io_reloc,
  input  logic [SLOTS-1:0]    slot_irq_in,
  output logic [SLOTS-1:0]    irq_out
);
  localparam int IDX_W = $clog2(CFG_WORDS);

  hit_e        hit;
  logic        wr_evt;
  logic        port_ready;
  logic [31:0] port_rdata, cfg_word, caddr, mbase, iobase;

  assign hit       = decode(bus_addr);
  assign bus_ready = (hit == HIT_DPORT) ? port_ready : 1'b1;
  assign wr_evt    = bus_sel && bus_wr && bus_ready;

  pcib_cfgspace #(.WORDS(CFG_WORDS)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .we(wr_evt && hit == HIT_CFG),
    .idx(bus_addr[IDX_W+1:2]),
    .wdata(bus_wdata),
    .rdata(cfg_word)
  );

  pcib_winregs u_win (
    .clk(clk), .rst_n(rst_n),
    .we_caddr(wr_evt && hit == HIT_CADDR),
    .we_mbase(wr_evt && hit == HIT_MBASE),
    .we_iobase(wr_evt && hit == HIT_IOBASE),
    .wdata(bus_wdata),
    .caddr(caddr), .mbase(mbase), .iobase(iobase),
    .io_base(io_base), .io_reloc(io_reloc)
  );

  pcib_cfgport u_port (
    .clk(clk), .rst_n(rst_n),
    .acc(bus_sel && hit == HIT_DPORT),
    .acc_wr(bus_wr), .acc_addr(caddr), .acc_wdata(bus_wdata),
    .port_ready(port_ready), .port_rdata(port_rdata),
    .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_done(cfg_done)
  );

  pcib_irqroute #(.SLOTS(SLOTS)) u_irq (
    .slot_irq_in(slot_irq_in), .irq_out(irq_out)
  );

  always_comb begin
    case (hit)
      HIT_CFG:    bus_rdata = cfg_word;
      HIT_CADDR:  bus_rdata = caddr;
      HIT_MBASE:  bus_rdata = mbase;
      HIT_IOBASE: bus_rdata = iobase;
      HIT_DPORT:  bus_rdata = port_rdata;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pcib_regif_chk.sv
module pcib_regif_chk
  import pcib_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_rdata,
  input logic                bus_ready,
  input logic                cfg_req,
  input logic                cfg_wr,
  input logic [31:0]         cfg_addr,
  input logic                cfg_done,
  input logic [IOBASE_W-1:0] io_base,
  input logic                io_reloc
);
  assert_reloc_moves_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io_reloc |-> (io_base != $past(io_base)));

  assert_base_move_pulses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_base != $past(io_base)) |-> io_reloc);

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_done) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_wr)));

  assert_stall_while_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !bus_ready);

  assert_mbase_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_ready && !bus_wr && bus_addr == OFS_MBASE) |-> ((bus_rdata & ~MBASE_KEEP) == 32'h0));

  assert_high_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr >= 10'h224) |-> (bus_rdata == 32'h0));

  assert_reg_no_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr != OFS_DPORT) |-> bus_ready);
endmodule

bind pcib_regif pcib_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
  .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_done(cfg_done), .io_base(io_base), .io_reloc(io_reloc)
);

// File: tb/pcib_regif_test.sv
`timescale 1ns/1ps
module pcib_regif_test;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_ready;
  logic        cfg_req, cfg_wr, cfg_done = 0;
  logic [31:0] cfg_addr, cfg_wdata, cfg_rdata = '0;
  logic [13:0] io_base;
  logic        io_reloc;
  logic [3:0]  slot_irq_in = '0, irq_out;

  always #5 clk = ~clk;

  pcib_regif uut (.*);

  int vectors = 0, miscompares = 0;
  logic [31:0] m_cfg [64];
  logic [31:0] m_caddr, m_mbase, m_iobase;
  logic        post_reloc;
  logic [13:0] post_base;
  int          reloc_seen = 0, reloc_exp = 0;
  int          lat = 0, wcnt = 0;
  logic        r_wr;
  logic [31:0] r_addr, r_wdata;

  function automatic logic [31:0] resp_fn(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // downstream responder, latency lat cycles after cfg_req rises
  always @(negedge clk) begin
    if (cfg_done) begin
      cfg_done <= 0; wcnt <= 0;
    end else if (cfg_req) begin
      if (wcnt >= lat) begin
        cfg_done <= 1; cfg_rdata <= resp_fn(cfg_addr);
        r_wr <= cfg_wr; r_addr <= cfg_addr; r_wdata <= cfg_wdata;
      end else wcnt <= wcnt + 1;
    end
  end

  always @(negedge clk) if (rst_n && io_reloc) reloc_seen++;

  task automatic access(input logic wr, input logic [9:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int stall);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d; stall = 0;
    forever begin
      #1;
      if (bus_ready) begin rd = bus_rdata; break; end
      stall++;
      @(negedge clk);
    end
    @(posedge clk); #1;
    post_reloc = io_reloc; post_base = io_base;
    bus_sel = 0; bus_wr = 0;
  endtask

  function automatic logic [31:0] model_read(input logic [9:0] a);
    if (a[1:0] != 0) return 0;
    if (a[9:8] == 0) return m_cfg[a[7:2]];
    case (a)
      10'h1C0: return m_caddr;
      10'h1C4: return m_mbase;
      10'h1C8: return m_iobase;
      default: return 0;
    endcase
  endfunction

  task automatic do_write(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] rd; int st; bit mv;
    mv = 0;
    if (a[1:0] == 0 && a[9:8] == 0) m_cfg[a[7:2]] = d;
    else if (a == 10'h1C0) m_caddr = d;
    else if (a == 10'h1C4) m_mbase = d & 32'hFF00_0001;
    else if (a == 10'h1C8 && d[31:18] != m_iobase[31:18]) begin
      m_iobase = d & 32'hFFFC_0001; mv = 1; reloc_exp++;
    end
    access(1, a, d, rd, st);
    if (a == 10'h220) begin
      check(st >= 1, "R7 stall", st, 1);
      check(r_wr && r_addr == m_caddr, "R7 addr", r_addr, m_caddr);
      check(r_wdata == d, "R7 wdata", r_wdata, d);
    end else begin
      check(st == 0, "R11 no stall", st, 0);
    end
    if (a == 10'h1C8) begin
      check(post_reloc == mv, "R6 pulse", post_reloc, mv);
      check(post_base == m_iobase[31:18], "R6 base", post_base, m_iobase[31:18]);
    end else check(!post_reloc, "R6 spurious pulse", post_reloc, 0);
  endtask

  task automatic do_read(input logic [9:0] a, input string req);
    logic [31:0] rd, ex; int st;
    access(0, a, 0, rd, st);
    if (a == 10'h220) begin
      ex = resp_fn(m_caddr);
      check(!r_wr && r_addr == m_caddr, "R8 addr", r_addr, m_caddr);
    end else ex = model_read(a);
    check(rd == ex, req, rd, ex);
  endtask

  function automatic string tag_for(input logic [9:0] a);
    if (a[1:0] != 0) return "R9";
    if (a[9:8] == 0) return "R2";
    case (a)
      10'h1C0: return "R3";
      10'h1C4: return "R4";
      10'h1C8: return "R5";
      10'h220: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [9:0] pick_addr();
    case ($urandom_range(0, 7))
      0, 1: return {2'b00, 6'($urandom_range(0, 63)), 2'b00};
      2: return 10'h1C0;
      3: return 10'h1C4;
      4: return 10'h1C8;
      5: return 10'h220;
      6: return 10'($urandom_range(0, 1023));
      default: return {8'($urandom_range(64, 255)), 2'b00};
    endcase
  endfunction

  initial begin
    #1_500_000;
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int i = 0; i < 64; i++) m_cfg[i] = (i == 1) ? 32'h0290_0080 : 32'h0;
    m_caddr = 0; m_mbase = 0; m_iobase = 32'hFE24_0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    #2 check(io_base == 14'h3F89 && !io_reloc, "R1 io_base", io_base, 14'h3F89);
    do_read(10'h1C8, "R1 iobase");
    do_read(10'h1C0, "R1 caddr");
    do_read(10'h1C4, "R1 mbase");
    do_read(10'h004, "R1 cmd/status");
    do_read(10'h000, "R1 word0");
    do_read(10'h0FC, "R1 last word");
    // directed corners
    do_write(10'h0FC, 32'hDEAD_BEEF); do_read(10'h0FC, "R2 top word");
    do_write(10'h1C0, 32'hFFFF_FFFF); do_read(10'h1C0, "R3 all ones");
    do_write(10'h1C4, 32'hFFFF_FFFF); do_read(10'h1C4, "R4 mask");
    do_write(10'h1C8, 32'hFE27_FFFF); do_read(10'h1C8, "R5 same upper ignored");
    do_write(10'h1C8, 32'h1234_5679); do_read(10'h1C8, "R5 move masked");
    do_write(10'h1C8, 32'h1234_0000); do_read(10'h1C8, "R5 bit0 kept");
    do_write(10'h100, 32'hAAAA_5555); do_read(10'h100, "R9 gap read");
    do_write(10'h1C9, 32'h0000_0000); do_read(10'h1C8, "R9 misaligned write");
    do_write(10'h224, 32'h5555_AAAA); do_read(10'h224, "R9 past window");
    do_read(10'h3FC, "R9 top offset");
    do_write(10'h1C0, 32'h8000_0810);
    lat = 0; do_write(10'h220, 32'hCAFE_0001); do_read(10'h220, "R8 zero latency");
    lat = 3; do_write(10'h220, 32'hCAFE_0002); do_read(10'h220, "R8 long latency");
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); slot_irq_in = 4'(1 << s); #1;
      check(irq_out == slot_irq_in, "R10 slot route", irq_out, slot_irq_in);
    end
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [9:0] a; logic [31:0] d;
      a = pick_addr(); d = $urandom();
      lat = $urandom_range(0, 3);
      if (a == 10'h1C8 && $urandom_range(0, 1) == 1) d[31:18] = m_iobase[31:18];
      if ($urandom_range(0, 1) == 1) do_write(a, d);
      else do_read(a, tag_for(a));
      if (n % 16 == 0) begin
        @(negedge clk); slot_irq_in = 4'($urandom()); #1;
        check(irq_out == slot_irq_in, "R10 random", irq_out, slot_irq_in);
      end
    end
    repeat (2) @(negedge clk);
    check(reloc_seen == reloc_exp, "R6 pulse count", reloc_seen, reloc_exp);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule